// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a bus-mapped watchdog. A 16-bit down-counter is clocked by a two-stage timebase. The first stage is an 8-bit prescaler that divides the input clock by P+1. The second stage is a fixed divider, chosen by a 2-bit field, that divides by 16, 32, 64 or 128. Software keeps the system alive by rewriting the counter before it runs out.

When the counter is already at zero and another timebase tick arrives, the counter reloads from a data register and the block signals expiry. The expiry can set a sticky interrupt line, start a reset-request pulse of fixed length, do both, or do neither. Each of these two actions has its own enable bit.

The block has four word registers at offsets 0x0, 0x4, 0x8 and 0xC: control, reload value, live counter and interrupt acknowledge. All of them can be written while the timer is stopped, so software can set up the next start.

Top module: `wdog_periph`

## Requirements
- R1: After reset, the control register reads 0x8039: enable set, reset action set, interrupt action clear, divider select 3 and prescaler 0x80. The reload and counter registers read 0x8000, and both `irq_o` and `rst_req_o` are low.
- R2: Registers sit at offset 0x0 (control), 0x4 (reload) and 0x8 (counter). In the control register, bit 0 is the reset action, bit 2 the interrupt action, bits [4:3] the divider select, bit 5 the enable and bits [15:8] the prescaler. Every other control bit reads 0. Reload and counter keep bits [15:0]. Offset 0xC reads 0. Read data appears on `bus_rdata` one cycle after the `bus_rd` cycle.
- R3: While enable is clear, the counter holds its value, and writes to all registers still take effect.
- R4: While enabled, the counter decreases by one every (P+1)·D input clocks. D is 16, 32, 64 or 128 for select values 0 to 3.
- R5: A write to the counter register loads the written value at that clock edge, even while the timer is running, and takes priority over a tick.
- R6: A tick that arrives while the counter is 0 reloads the counter from the reload register and marks an expiry.
- R7: An expiry with the interrupt action set raises `irq_o`, which stays high until a write with bit 0 = 1 to offset 0xC. A write with bit 0 = 0 leaves it set.
- R8: An expiry with the reset action set drives `rst_req_o` high for exactly RST_CYCLES (default 8) clocks. With the action clear, `rst_req_o` stays low.
- R9: Clearing enable resets both timebase stages. After enable is set again, the first decrement comes one full period (P+1)·D after the enabling write, whatever the timebase held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | Expiry reset-request pulse |

## Verification
The hardest case to reach is the restart rule. A disable and re-enable must throw away a partly filled timebase, and from the ports this only shows up as the time of the first decrement. The stimulus lets the prescaler run most of a short period, stops the timer, restarts it at once, and reads the counter both before and after the point where a stale timebase would have ticked. Expiry is reached by loading a small count under the fastest timebase. The reset pulse is then measured by counting high cycles with a free-running sampler.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W   = 16;
  localparam int PRE_W   = 8;
  localparam int SEL_W   = 2;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 4'hC;

  localparam int BIT_RST = 0;
  localparam int BIT_IRQ = 2;
  localparam int BIT_SEL = 3;
  localparam int BIT_EN  = 5;
  localparam int BIT_PRE = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
  parameter int PRE_W     = 8,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int DIV_W = BASE_LOG2 + NSEL - 1;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             pre_wrap, div_wrap;

  always_comb begin
    div_last = '0;
    for (int i = 0; i < NSEL; i++)
      if (sel == SEL_W'(i)) div_last = DIV_W'((1 << (BASE_LOG2 + i)) - 1);
  end

  assign pre_wrap = (pre_cnt == pre_val);
  assign div_wrap = (div_cnt == div_last);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= pre_wrap && div_wrap;
      if (pre_wrap) begin
        pre_cnt <= '0;
        div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R4: a tick only follows a cycle in which the timer was enabled
  assert_tick_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int                 CNT_W      = 16,
  parameter int                 RST_CYCLES = 8,
  parameter logic [CNT_W-1:0]   RESET_CNT  = 16'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reload,
  input  logic             en,
  input  logic             irq_en,
  input  logic             rst_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             rst_req
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0] rst_left;
  logic            expire;

  assign expire = tick && (cnt == '0) && !cnt_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= RESET_CNT;
      irq      <= 1'b0;
      rst_left <= '0;
      rst_req  <= 1'b0;
    end else begin
      if (cnt_wr)    cnt <= cnt_wdata;
      else if (tick) cnt <= (cnt == '0) ? reload : cnt - 1'b1;

      if (expire && irq_en) irq <= 1'b1;
      else if (irq_clr)     irq <= 1'b0;

      if (expire && rst_en) begin
        rst_left <= RC_W'(RST_CYCLES);
        rst_req  <= 1'b1;
      end else begin
        if (rst_left != '0) rst_left <= rst_left - 1'b1;
        rst_req <= (rst_left > RC_W'(1));
      end
    end
  end

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!en && !tick && !cnt_wr) |=> $stable(cnt));
  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  assert_reload_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && cnt == '0) |=> (cnt == $past(reload)));
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  assert_rst_from_expiry_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(expire && rst_en));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_LOAD = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_wr,
  output logic              irq_clr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] ctrl_word;

  assign cnt_wr  = bus_wr && (bus_addr == OFS_CNT);
  assign irq_clr = bus_wr && (bus_addr == OFS_ACK) && bus_wdata[0];

  always_comb begin
    ctrl_word = '0;
    ctrl_word[BIT_RST]                 = ctrl.rst_en;
    ctrl_word[BIT_IRQ]                 = ctrl.irq_en;
    ctrl_word[BIT_SEL +: SEL_W]        = ctrl.sel;
    ctrl_word[BIT_EN]                  = ctrl.en;
    ctrl_word[BIT_PRE +: PRE_W]        = ctrl.pre;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: rd_mux = ctrl_word;
      OFS_LOAD: rd_mux = DATA_W'(reload);
      OFS_CNT:  rd_mux = DATA_W'(cnt);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.rst_en <= 1'b1;
      ctrl.irq_en <= 1'b0;
      ctrl.sel    <= '1;
      ctrl.en     <= 1'b1;
      ctrl.pre    <= PRE_W'(8'h80);
      reload      <= RESET_LOAD;
      bus_rdata   <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_CTRL) begin
        ctrl.rst_en <= bus_wdata[BIT_RST];
        ctrl.irq_en <= bus_wdata[BIT_IRQ];
        ctrl.sel    <= bus_wdata[BIT_SEL +: SEL_W];
        ctrl.en     <= bus_wdata[BIT_EN];
        ctrl.pre    <= bus_wdata[BIT_PRE +: PRE_W];
      end
      if (bus_wr && bus_addr == OFS_LOAD) reload <= bus_wdata[CNT_W-1:0];
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CTRL) |=> (ctrl.pre == $past(bus_wdata[BIT_PRE +: PRE_W])));
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
  import wdog_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             cnt_wr, irq_clr, tick;

  wdog_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt),
    .ctrl(ctrl), .reload(reload), .cnt_wr(cnt_wr), .irq_clr(irq_clr),
    .bus_rdata(bus_rdata)
  );

  wdog_tickgen #(.PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG2(4)) u_tick (
    .clk(clk), .rst(rst), .en(ctrl.en), .pre_val(ctrl.pre),
    .sel(ctrl.sel), .tick(tick)
  );

  wdog_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wdata(bus_wdata[CNT_W-1:0]), .reload(reload), .en(ctrl.en),
    .irq_en(ctrl.irq_en), .rst_en(ctrl.rst_en), .irq_clr(irq_clr),
    .cnt(cnt), .irq(irq_o), .rst_req(rst_req_o)
  );
endmodule

// File: tb/tb_wdog_periph.sv
`timescale 1ns/1ps
module tb_wdog_periph;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;

  int n_chk = 0, n_fail = 0, rst_hi = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  wdog_periph dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk) if (rst_req_o) rst_hi++;

  // {addr, write data, expected readback}
  localparam logic [67:0] VEC [0:4] = '{
    {4'h0, 32'h0000_12DF, 32'h0000_121D},
    {4'h4, 32'hABCD_1234, 32'h0000_1234},
    {4'h8, 32'h0000_BEEF, 32'h0000_BEEF},
    {4'hC, 32'h0000_0001, 32'h0000_0000},
    {4'h0, 32'h0000_FF1D, 32'h0000_FF1D}
  };

  function automatic logic [31:0] mkctrl(input int p, input int s,
                                          input bit ie, input bit re, input bit en);
    return (32'(p) << 8) | (32'(s) << 3) | (32'(en) << 5) | (32'(ie) << 2) | 32'(re);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
  endtask

  task automatic check_reset();
    rd(4'h0, rv); chk("R1 ctrl", rv, 32'h0000_8039);
    rd(4'h4, rv); chk("R1 load", rv, 32'h0000_8000);
    rd(4'h8, rv); chk("R1 cnt", rv, 32'h0000_8000);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rstreq", 32'(rst_req_o), 0);
  endtask

  task automatic run_rate(input int p, input int s, input int start);
    int per;
    per = (p + 1) * (16 << s);
    wr(4'h0, mkctrl(p, s, 0, 0, 0));
    wr(4'h8, 32'(start));
    wr(4'h0, mkctrl(p, s, 0, 0, 1));
    repeat (2 * per + per / 2) @(negedge clk);
    rd(4'h8, rv); chk("R4 rate", rv, 32'(start - 2));
    wr(4'h0, mkctrl(p, s, 0, 0, 0));
  endtask

  initial begin
    int base;
    do_reset();
    check_reset();

    // R2 / R3: table walk with the timer stopped by the first entry
    foreach (VEC[i]) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], rv);
      chk("R2 readback", rv, VEC[i][31:0]);
    end
    wr(4'h0, mkctrl(0, 0, 0, 0, 0));
    repeat (100) @(negedge clk);
    rd(4'h8, rv); chk("R3 hold while off", rv, 32'h0000_BEEF);

    run_rate(1, 1, 100);
    run_rate(2, 2, 50);
    run_rate(0, 3, 20);
    run_rate(0, 0, 9);

    // R5: keepalive while running
    wr(4'h8, 32'd500);
    wr(4'h0, mkctrl(0, 0, 0, 0, 1));
    repeat (40) @(negedge clk);
    wr(4'h8, 32'h0000_0042);
    rd(4'h8, rv); chk("R5 keepalive", rv, 32'h0000_0042);

    // R9: restart discards a partly filled timebase
    wr(4'h0, mkctrl(0, 0, 0, 0, 0));
    wr(4'h8, 32'd200);
    wr(4'h0, mkctrl(0, 0, 0, 0, 1));
    repeat (10) @(negedge clk);
    wr(4'h0, mkctrl(0, 0, 0, 0, 0));
    wr(4'h0, mkctrl(0, 0, 0, 0, 1));
    repeat (12) @(negedge clk);
    rd(4'h8, rv); chk("R9 no early tick", rv, 32'd200);
    repeat (7) @(negedge clk);
    rd(4'h8, rv); chk("R9 full period", rv, 32'd199);

    // R6 / R7 / R8: expiry with both actions
    wr(4'h0, mkctrl(0, 0, 0, 0, 0));
    wr(4'hC, 32'h1);
    wr(4'h4, 32'd3);
    wr(4'h8, 32'd1);
    base = rst_hi;
    wr(4'h0, mkctrl(0, 0, 1, 1, 1));
    repeat (40) @(negedge clk);
    rd(4'h8, rv); chk("R6 reload", rv, 32'd3);
    chk("R8 pulse width", 32'(rst_hi - base), 32'd8);
    chk("R7 irq set", 32'(irq_o), 1);
    wr(4'hC, 32'h0);
    chk("R7 zero write keeps irq", 32'(irq_o), 1);
    wr(4'hC, 32'h1);
    chk("R7 clear", 32'(irq_o), 0);
    wr(4'h0, mkctrl(0, 0, 0, 0, 0));

    // R8: reset action off
    wr(4'h8, 32'd1);
    base = rst_hi;
    wr(4'h0, mkctrl(0, 0, 1, 0, 1));
    repeat (45) @(negedge clk);
    chk("R8 no pulse", 32'(rst_hi - base), 0);
    chk("R7 irq only", 32'(irq_o), 1);
    wr(4'h0, mkctrl(0, 0, 0, 0, 0));
    wr(4'hC, 32'h1);

    do_reset();
    check_reset();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule